// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block owns the program counter of a 32-bit RISC core whose instructions are all one 32-bit word long. Each cycle it looks at the current PC, the instruction word fetched from it, and the values read from the two source registers that the instruction names. From these it works out where execution continues. When the caller also needs a return address, the block reports which register receives it and what that value is. The PC register advances only in cycles in which the valid input is high.

The unit handles five kinds of control flow. Absolute jumps and calls splice a 26-bit word index under the four top PC bits. PC-relative branches add a signed 16-bit byte offset to the address of the following word; the conditional ones compare two registers, signed or unsigned. Register-indirect jumps, returns and calls take their target from the first source register. Every other word, including unknown encodings, falls through to PC+4. Register index 0 is hard-wired to zero. A link write aimed at it is dropped.

Top module: `flow_nextpc`

## Requirements
- R1: While rst_n is low, pc_o becomes 0 at each rising clock edge. After reset the first observed pc_o is 0.
- R2: On a rising edge with valid_i high, pc_o takes the value next_pc_o had before that edge. With valid_i low, pc_o holds.
- R3: Primary opcode (bits 5:0) 0x00 is a call. next_pc_o is {pc_o[31:28], instr_i[31:6], 2'b00}. link_we_o is 1, link_idx_o is 31 and link_val_o is pc_o+4.
- R4: Opcode 0x01 gives the same spliced target as R3 and makes no link write.
- R5: Opcode 0x06 gives next_pc_o = pc_o + 4 + sign-extended instr_i[21:6], with no scaling of the offset.
- R6: The conditional opcodes compare operand A against operand B. 0x0E is signed A>=B, 0x16 is signed A<B, 0x1E is A!=B, 0x26 is A==B, 0x2E is unsigned A>=B and 0x36 is unsigned A<B. When the condition holds the target is the R5 target, otherwise it is pc_o+4.
- R7: Operand A is the register named by bits 31:27 and operand B the one named by bits 26:22. When such an index is 0, the operand is 0 whatever value is on rs_a_i or rs_b_i.
- R8: With opcode 0x3A, the function field is bits 16:11. Functions 0x01, 0x05, 0x09 and 0x0D set next_pc_o to operand A and make no link write.
- R9: With opcode 0x3A, function 0x1D jumps to operand A. Function 0x1C continues at pc_o+4. Both request a link of pc_o+4 into the register named by bits 21:17.
- R10: link_we_o is never 1 while link_idx_o is 0.
- R11: Every other opcode, and every other function under 0x3A, gives next_pc_o = pc_o+4 with link_we_o low.
- R12: link_we_o is low whenever valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | The instruction on instr_i is accepted this cycle |
| instr_i | input | 32 | Instruction word fetched at pc_o |
| rs_a_i | input | 32 | Value of the register named by bits 31:27 |
| rs_b_i | input | 32 | Value of the register named by bits 26:22 |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address of the instruction that follows |
| link_we_o | output | 1 | A return address is to be written |
| link_idx_o | output | 5 | Destination register of the return address |
| link_val_o | output | 32 | Return address (pc_o+4) |

## Verification
The assertions take valid_i, instr_i and the operand inputs to be known and steady at each rising edge. They also expect reset to be held for at least one edge before any checked behaviour begins. The bench changes every input only on the falling edge and holds rst_n low for several cycles at the start and again midway. It samples the combinational outputs one time unit after driving them. Register jumps use word-aligned addresses, so the reference model in the bench never has to reason about misaligned PCs.

// File: rtl/flow_pkg.sv
package flow_pkg;

    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int OP_W    = 6;

    localparam logic [OP_W-1:0] OP_CALL = 6'h00;
    localparam logic [OP_W-1:0] OP_JMPI = 6'h01;
    localparam logic [OP_W-1:0] OP_BR   = 6'h06;
    localparam logic [OP_W-1:0] OP_BGE  = 6'h0E;
    localparam logic [OP_W-1:0] OP_BLT  = 6'h16;
    localparam logic [OP_W-1:0] OP_BNE  = 6'h1E;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'h26;
    localparam logic [OP_W-1:0] OP_BGEU = 6'h2E;
    localparam logic [OP_W-1:0] OP_BLTU = 6'h36;
    localparam logic [OP_W-1:0] OP_RGRP = 6'h3A;

    localparam logic [OP_W-1:0] FX_ERET   = 6'h01;
    localparam logic [OP_W-1:0] FX_RET    = 6'h05;
    localparam logic [OP_W-1:0] FX_BRET   = 6'h09;
    localparam logic [OP_W-1:0] FX_JMP    = 6'h0D;
    localparam logic [OP_W-1:0] FX_NEXTPC = 6'h1C;
    localparam logic [OP_W-1:0] FX_CALLR  = 6'h1D;

    localparam logic [RIDX_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [1:0] {
        TK_SEQ,
        TK_ABS,
        TK_BRANCH,
        TK_IND
    } tgt_kind_e;

    typedef enum logic [2:0] {
        CC_ALWAYS,
        CC_GE,
        CC_LT,
        CC_NE,
        CC_EQ,
        CC_GEU,
        CC_LTU
    } cond_e;

    typedef struct packed {
        tgt_kind_e         kind;
        cond_e             cond;
        logic              link;
        logic [RIDX_W-1:0] link_idx;
    } flow_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

endpackage

// File: rtl/flow_decode.sv
module flow_decode
    import flow_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [OP_W-1:0]   fx_i,
    input  logic [RIDX_W-1:0] c_idx_i,
    output flow_dec_t         dec_o
);

    always_comb begin
        dec_o          = '0;
        dec_o.kind     = TK_SEQ;
        dec_o.cond     = CC_ALWAYS;
        dec_o.link     = 1'b0;
        dec_o.link_idx = '0;
        unique case (op_i)
            OP_CALL: begin
                dec_o.kind     = TK_ABS;
                dec_o.link     = 1'b1;
                dec_o.link_idx = LINK_REG;
            end
            OP_JMPI: dec_o.kind = TK_ABS;
            OP_BR:   dec_o.kind = TK_BRANCH;
            OP_BGE:  begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_GE;  end
            OP_BLT:  begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_LT;  end
            OP_BNE:  begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_NE;  end
            OP_BEQ:  begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_EQ;  end
            OP_BGEU: begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_GEU; end
            OP_BLTU: begin dec_o.kind = TK_BRANCH; dec_o.cond = CC_LTU; end
            OP_RGRP: begin
                unique case (fx_i)
                    FX_ERET, FX_RET, FX_BRET, FX_JMP: dec_o.kind = TK_IND;
                    FX_CALLR: begin
                        dec_o.kind     = TK_IND;
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = c_idx_i;
                    end
                    FX_NEXTPC: begin
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = c_idx_i;
                    end
                    default: dec_o.kind = TK_SEQ;
                endcase
            end
            default: dec_o.kind = TK_SEQ;
        endcase
    end

endmodule

// File: rtl/flow_compare.sv
module flow_compare
    import flow_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  cond_e        cond_i,
    output logic         taken_o
);

    logic eq, lt_s, lt_u;

    always_comb begin
        eq   = (opa_i == opb_i);
        lt_s = ($signed(opa_i) < $signed(opb_i));
        lt_u = (opa_i < opb_i);
        unique case (cond_i)
            CC_GE:   taken_o = !lt_s;
            CC_LT:   taken_o = lt_s;
            CC_NE:   taken_o = !eq;
            CC_EQ:   taken_o = eq;
            CC_GEU:  taken_o = !lt_u;
            CC_LTU:  taken_o = lt_u;
            default: taken_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/flow_target.sv
module flow_target
    import flow_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int JW = JIDX_W,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  pc_i,
    input  logic [JW-1:0] jidx_i,
    input  logic [IW-1:0] imm_i,
    input  logic [W-1:0]  opa_i,
    input  tgt_kind_e     kind_i,
    input  logic          taken_i,
    output logic [W-1:0]  next_pc_o,
    output logic [W-1:0]  seq_pc_o
);

    localparam int SPLICE_W = JW + 2;
    localparam int KEEP_W   = W - SPLICE_W;

    logic [W-1:0] seq_pc, abs_pc, rel_pc, imm_sx;

    always_comb begin
        seq_pc = pc_i + W'(4);
        imm_sx = {{(W-IW){imm_i[IW-1]}}, imm_i};
        rel_pc = seq_pc + imm_sx;
        abs_pc = {pc_i[W-1 -: KEEP_W], jidx_i, 2'b00};
        unique case (kind_i)
            TK_ABS:    next_pc_o = abs_pc;
            TK_BRANCH: next_pc_o = taken_i ? rel_pc : seq_pc;
            TK_IND:    next_pc_o = opa_i;
            default:   next_pc_o = seq_pc;
        endcase
        seq_pc_o = seq_pc;
    end

endmodule

// File: rtl/flow_nextpc.sv
module flow_nextpc
    import flow_pkg::*;
#(
    parameter int W      = XLEN,
    parameter int IDX_W  = RIDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [31:0]      instr_i,
    input  logic [W-1:0]     rs_a_i,
    input  logic [W-1:0]     rs_b_i,
    output logic [W-1:0]     pc_o,
    output logic [W-1:0]     next_pc_o,
    output logic             link_we_o,
    output logic [IDX_W-1:0] link_idx_o,
    output logic [W-1:0]     link_val_o
);

    localparam int NSRC = 2;

    // instruction fields
    logic [IDX_W-1:0]  a_idx, b_idx, c_idx;
    logic [IMM_W-1:0]  imm;
    logic [JIDX_W-1:0] jidx;
    logic [OP_W-1:0]   op, fx;

    assign a_idx = instr_i[31:27];
    assign b_idx = instr_i[26:22];
    assign c_idx = instr_i[21:17];
    assign imm   = instr_i[21:6];
    assign jidx  = instr_i[31:6];
    assign fx    = instr_i[16:11];
    assign op    = instr_i[5:0];

    // operand fetch with index 0 forced to zero
    logic [W-1:0]     src_raw [NSRC];
    logic [IDX_W-1:0] src_idx [NSRC];
    logic [W-1:0]     src_val [NSRC];

    assign src_raw[0] = rs_a_i;
    assign src_raw[1] = rs_b_i;
    assign src_idx[0] = a_idx;
    assign src_idx[1] = b_idx;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_val[g] = (src_idx[g] == '0) ? '0 : src_raw[g];
    end

    flow_dec_t   dec;
    logic        taken;
    logic [W-1:0] tgt, seq_pc;
    pc_state_t   st_d, st_q;

    flow_decode u_dec (
        .op_i    (op),
        .fx_i    (fx),
        .c_idx_i (c_idx),
        .dec_o   (dec)
    );

    flow_compare #(.W(W)) u_cmp (
        .opa_i   (src_val[0]),
        .opb_i   (src_val[1]),
        .cond_i  (dec.cond),
        .taken_o (taken)
    );

    flow_target #(.W(W), .JW(JIDX_W), .IW(IMM_W)) u_tgt (
        .pc_i      (st_q.pc),
        .jidx_i    (jidx),
        .imm_i     (imm),
        .opa_i     (src_val[0]),
        .kind_i    (dec.kind),
        .taken_i   (taken),
        .next_pc_o (tgt),
        .seq_pc_o  (seq_pc)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.pc = tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign next_pc_o  = tgt;
    assign link_idx_o = dec.link_idx;
    assign link_we_o  = valid_i && dec.link && (dec.link_idx != '0);
    assign link_val_o = seq_pc;

endmodule

// File: rtl/flow_nextpc_chk.sv
module flow_nextpc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic [5:0]  op_i,
    input logic [31:0] pc_o,
    input logic [31:0] next_pc_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o
);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pc_o == 32'd0);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(pc_o));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> pc_o == $past(next_pc_o));

    assert_call_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 6'h00) |-> (link_we_o && link_idx_o == 5'd31));

    assert_no_zero_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_idx_o != 5'd0);

    assert_link_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> valid_i);

endmodule

bind flow_nextpc flow_nextpc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .op_i       (instr_i[5:0]),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o)
);

// File: tb/tb_flow_nextpc.sv
`timescale 1ns/1ps
module tb_flow_nextpc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs_a_i = '0;
    logic [31:0] rs_b_i = '0;
    logic [31:0] pc_o, next_pc_o, link_val_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;

    always #2.5 clk = ~clk;

    flow_nextpc dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .instr_i    (instr_i),
        .rs_a_i     (rs_a_i),
        .rs_b_i     (rs_b_i),
        .pc_o       (pc_o),
        .next_pc_o  (next_pc_o),
        .link_we_o  (link_we_o),
        .link_idx_o (link_idx_o),
        .link_val_o (link_val_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic [31:0] nxt;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int total = 0;
    int bad = 0;
    logic [31:0] model_pc = '0;

    function automatic logic [31:0] mk_i(input logic [4:0] a, input logic [4:0] b,
                                         input logic [15:0] imm, input logic [5:0] op);
        return {a, b, imm, op};
    endfunction

    function automatic logic [31:0] mk_j(input logic [25:0] idx, input logic [5:0] op);
        return {idx, op};
    endfunction

    function automatic logic [31:0] mk_r(input logic [4:0] a, input logic [4:0] b,
                                         input logic [4:0] c, input logic [5:0] fx);
        return {a, b, c, fx, 5'd0, 6'h3A};
    endfunction

    // reference model written from the requirements
    function automatic exp_t model(input logic v, input logic [31:0] ins,
                                   input logic [31:0] ra, input logic [31:0] rb,
                                   input logic [31:0] pc);
        exp_t e;
        logic [31:0] a, b, seq, rel;
        logic [5:0] op, fx;
        logic take;
        a   = (ins[31:27] == 0) ? 32'd0 : ra;
        b   = (ins[26:22] == 0) ? 32'd0 : rb;
        op  = ins[5:0];
        fx  = ins[16:11];
        seq = pc + 32'd4;
        rel = seq + {{16{ins[21]}}, ins[21:6]};
        e.pc = pc; e.nxt = seq; e.we = 1'b0; e.idx = 5'd0; e.val = seq; e.tag = "";
        take = 1'b0;
        case (op)
            6'h00: begin e.nxt = {pc[31:28], ins[31:6], 2'b00}; e.we = 1'b1; e.idx = 5'd31; end
            6'h01: e.nxt = {pc[31:28], ins[31:6], 2'b00};
            6'h06: e.nxt = rel;
            6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36: begin
                case (op)
                    6'h0E: take = $signed(a) >= $signed(b);
                    6'h16: take = $signed(a) <  $signed(b);
                    6'h1E: take = a != b;
                    6'h26: take = a == b;
                    6'h2E: take = a >= b;
                    default: take = a < b;
                endcase
                e.nxt = take ? rel : seq;
            end
            6'h3A: begin
                if (fx == 6'h01 || fx == 6'h05 || fx == 6'h09 || fx == 6'h0D) e.nxt = a;
                else if (fx == 6'h1D) begin e.nxt = a; e.idx = ins[21:17]; e.we = 1'b1; end
                else if (fx == 6'h1C) begin e.idx = ins[21:17]; e.we = 1'b1; end
            end
            default: ;
        endcase
        if (e.idx == 0 || !v) e.we = 1'b0;
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] ra,
                        input logic [31:0] rb, input string tag);
        exp_t e;
        @(negedge clk);
        valid_i = v; instr_i = ins; rs_a_i = ra; rs_b_i = rb;
        e = model(v, ins, ra, rb, model_pc);
        e.tag = tag;
        exp_q.push_back(e);
        #1 ->sample_ev;
        if (v) model_pc = e.nxt;
    endtask

    // monitor
    initial begin
        forever begin
            exp_t e;
            @(sample_ev);
            e = exp_q.pop_front();
            check(pc_o == e.pc, e.tag, "pc", pc_o, e.pc);
            check(next_pc_o == e.nxt, e.tag, "next_pc", next_pc_o, e.nxt);
            check(link_we_o == e.we, e.tag, "link_we", {31'd0, link_we_o}, {31'd0, e.we});
            if (e.we) begin
                check(link_idx_o == e.idx, e.tag, "link_idx", {27'd0, link_idx_o}, {27'd0, e.idx});
                check(link_val_o == e.val, e.tag, "link_val", link_val_o, e.val);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; valid_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_pc = '0;
        #1;
        check(pc_o == 32'd0, "R1", "pc after reset", pc_o, 32'd0);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        do_reset();
        step(1, mk_i(5'd1, 5'd2, 16'h0010, 6'h04), 32'h1, 32'h2, "R11 addi");
        step(1, mk_r(5'd3, 5'd0, 5'd0, 6'h0D), 32'hF000_1000, 32'h0, "R8 jmp");
        step(0, mk_j(26'h0123456, 6'h00), 32'h0, 32'h0, "R2/R12 hold");
        step(1, mk_j(26'h0123456, 6'h00), 32'h0, 32'h0, "R3 call");
        step(1, mk_j(26'h0000800, 6'h01), 32'h0, 32'h0, "R4 jmpi");
        step(1, mk_i(5'd0, 5'd0, 16'h0010, 6'h06), 32'h0, 32'h0, "R5 br fwd");
        step(1, mk_i(5'd0, 5'd0, 16'hFFF8, 6'h06), 32'h0, 32'h0, "R5 br back");
        step(1, mk_i(5'd1, 5'd2, 16'h0040, 6'h0E), 32'hFFFF_FFFF, 32'h1, "R6 bge signed no");
        step(1, mk_i(5'd1, 5'd2, 16'h0040, 6'h2E), 32'hFFFF_FFFF, 32'h1, "R6 bgeu yes");
        step(1, mk_i(5'd1, 5'd2, 16'h0020, 6'h16), 32'hFFFF_FFFF, 32'h1, "R6 blt yes");
        step(1, mk_i(5'd1, 5'd2, 16'h0020, 6'h36), 32'hFFFF_FFFF, 32'h1, "R6 bltu no");
        step(1, mk_i(5'd1, 5'd2, 16'h0008, 6'h1E), 32'h5, 32'h5, "R6 bne no");
        step(1, mk_i(5'd1, 5'd2, 16'h0008, 6'h1E), 32'h5, 32'h6, "R6 bne yes");
        step(1, mk_i(5'd1, 5'd2, 16'hFFF0, 6'h26), 32'h9, 32'h9, "R6 beq yes");
        step(1, mk_i(5'd1, 5'd2, 16'h0100, 6'h0E), 32'h7, 32'h7, "R6 bge equal");
        step(1, mk_i(5'd0, 5'd2, 16'h0030, 6'h26), 32'h55, 32'h0, "R7 beq zero A");
        step(1, mk_i(5'd0, 5'd0, 16'h0030, 6'h1E), 32'h55, 32'h7, "R7 bne both zero");
        step(1, mk_r(5'd4, 5'd0, 5'd0, 6'h01), 32'hF000_2000, 32'h0, "R8 eret");
        step(1, mk_r(5'd4, 5'd0, 5'd0, 6'h09), 32'hF000_3000, 32'h0, "R8 bret");
        step(1, mk_r(5'd4, 5'd0, 5'd0, 6'h05), 32'h0000_4000, 32'h0, "R8 ret");
        step(1, mk_r(5'd6, 5'd0, 5'd5, 6'h1D), 32'h0000_8000, 32'h0, "R9 callr");
        step(1, mk_r(5'd0, 5'd0, 5'd7, 6'h1C), 32'h0, 32'h0, "R9 nextpc");
        step(1, mk_r(5'd6, 5'd0, 5'd0, 6'h1D), 32'h0000_9000, 32'h0, "R10 callr r0");
        step(1, mk_r(5'd0, 5'd0, 5'd0, 6'h1C), 32'h0, 32'h0, "R10 nextpc r0");
        step(1, mk_r(5'd0, 5'd0, 5'd0, 6'h0D), 32'h1234, 32'h0, "R7 jmp via r0");
        step(1, mk_i(5'd1, 5'd2, 16'h0040, 6'h3F), 32'h1, 32'h2, "R11 unknown op");
        step(1, mk_r(5'd1, 5'd2, 5'd4, 6'h31), 32'h1, 32'h2, "R11 rgrp add");
        step(0, mk_r(5'd6, 5'd0, 5'd5, 6'h1D), 32'h0000_A000, 32'h0, "R12 callr idle");
        step(1, mk_i(5'd1, 5'd2, 16'h0000, 6'h04), 32'h1, 32'h2, "R2 after idle");
        do_reset();
        step(1, mk_j(26'h3FFFFFF, 6'h00), 32'h0, 32'h0, "R3 call after reset");
        step(1, mk_i(5'd0, 5'd0, 16'h8000, 6'h06), 32'h0, 32'h0, "R5 br min offset");
        @(negedge clk);
        finish_up();
    end

endmodule